// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the word address for a four-beat memory burst. When a burst begins, it captures a two-bit starting offset and the upper address bits. After that it produces the address of each beat in turn, one beat for every clock in which the active-low step input is asserted. While the step input is negated, the burst is suspended and the address does not change. The upper address bits stay fixed for the whole burst. Only the two low bits move.

A static order input selects the beat sequence. Linear order counts upward from the start offset and wraps modulo four. Interleaved order XORs the start offset with the beat number. In both orders the fifth beat returns to the starting offset. Both orders share one two-bit beat counter, and the selected order is applied to that counter and the captured offset. The output is the full current word address. It is driven from registered state and changes on the clock edge after a load or a step.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `addr_o` is all zeros after that edge.
- R2: When `start_i` is high at an edge, after that edge the two low bits of `addr_o` equal `ofs_i` and the upper bits of `addr_o` equal `base_i`.
- R3: With `order_i` = 0 (linear), the k-th step after a load with offset s gives low bits (s + k) mod 4.
- R4: With `order_i` = 1 (interleaved), the k-th step after a load with offset s gives low bits s XOR (k mod 4).
- R5: An edge with `start_i` low and `step_n_i` high leaves `addr_o` unchanged (suspend).
- R6: In either order, four steps after a load return the low bits to the loaded offset.
- R7: An edge with `start_i` high and `step_n_i` low performs the load only. The low bits become `ofs_i`, not the stepped value.
- R8: Steps never change the upper bits of `addr_o`. A linear wrap from offset 3 to 0 does not carry into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst: capture `ofs_i` and `base_i` |
| step_n_i | input | 1 | Advance to the next beat when low; hold when high |
| order_i | input | 1 | Beat order: 0 linear, 1 interleaved; static |
| ofs_i | input | OFS_W (2) | Starting offset of the burst |
| base_i | input | ADDR_W-OFS_W (13) | Upper word-address bits of the burst |
| addr_o | output | ADDR_W (15) | Current word address |

## Verification
The properties assume that `order_i` stays constant between resets, because it is a static strap and is not registered. They also assume that `rst` is high from time zero. The hold and step properties still allow for an order change by excusing any cycle in which `order_i` moved. The stimulus changes `order_i` only together with a reset cycle. It then runs full bursts from every starting offset in both orders, mixing in suspends, loads that collide with a step, and a linear wrap under an all-ones upper field.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_addr_pkg::*;
(
    input  logic start_i,
    input  logic step_n_i,
    output cmd_e cmd_o
);
    // A load wins over a step presented in the same cycle.
    always_comb begin
        if (start_i)        cmd_o = CMD_LOAD;
        else if (!step_n_i) cmd_o = CMD_STEP;
        else                cmd_o = CMD_HOLD;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [OFS_W-1:0] beat_o,
    output logic [OFS_W-1:0] seed_o
);
    typedef struct packed {
        logic [OFS_W-1:0] beat;
        logic [OFS_W-1:0] seed;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        case (cmd_i)
            CMD_LOAD: begin
                ctr_d.seed = ofs_i;
                ctr_d.beat = '0;
            end
            CMD_STEP: ctr_d.beat = ctr_q.beat + 1'b1;
            default:  ctr_d = ctr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign beat_o = ctr_q.beat;
    assign seed_o = ctr_q.seed;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  order_e           order_i,
    input  logic [OFS_W-1:0] seed_i,
    input  logic [OFS_W-1:0] beat_i,
    output logic [OFS_W-1:0] low_o
);
    logic [OFS_W-1:0] lin_w;
    logic [OFS_W-1:0] xor_w;

    // Linear: modular sum, so the wrap never leaves the offset field.
    assign lin_w = seed_i + beat_i;

    // Interleaved: each offset bit is flipped by the matching beat bit.
    for (genvar b = 0; b < OFS_W; b++) begin : g_xor_bit
        assign xor_w[b] = seed_i[b] ^ beat_i[b];
    end

    assign low_o = (order_i == ORD_XOR) ? xor_w : lin_w;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int OFS_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    step_n_i,
    input  logic                    order_i,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [ADDR_W-OFS_W-1:0] base_i,
    output logic [ADDR_W-1:0]       addr_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [UP_W-1:0] upper;
    } up_t;

    cmd_e             cmd_w;
    logic [OFS_W-1:0] beat_w;
    logic [OFS_W-1:0] seed_w;
    logic [OFS_W-1:0] low_w;
    order_e           order_w;
    up_t              up_d, up_q;

    assign order_w = order_e'(order_i);

    burst_cmd_decode u_dec (
        .start_i  (start_i),
        .step_n_i (step_n_i),
        .cmd_o    (cmd_w)
    );

    burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd_w),
        .ofs_i  (ofs_i),
        .beat_o (beat_w),
        .seed_o (seed_w)
    );

    burst_order_map #(.OFS_W(OFS_W)) u_map (
        .order_i (order_w),
        .seed_i  (seed_w),
        .beat_i  (beat_w),
        .low_o   (low_w)
    );

    // Upper bits change only on a load.
    always_comb begin
        up_d = up_q;
        if (cmd_w == CMD_LOAD) up_d.upper = base_i;
    end

    always_ff @(posedge clk) begin
        if (rst) up_q <= '0;
        else     up_q <= up_d;
    end

    assign addr_o = {up_q.upper, low_w};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 15,
    parameter int OFS_W  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input logic                    step_n_i,
    input logic                    order_i,
    input logic [OFS_W-1:0]        ofs_i,
    input logic [ADDR_W-OFS_W-1:0] base_i,
    input logic [ADDR_W-1:0]       addr_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] low_w;
    logic [UP_W-1:0]  up_w;
    assign low_w = addr_o[OFS_W-1:0];
    assign up_w  = addr_o[ADDR_W-1:OFS_W];

    // R1
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> addr_o == '0);

    // R2
    p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (low_w == $past(ofs_i)) && (up_w == $past(base_i)));

    // R3
    p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !step_n_i && !order_i) |=>
            (order_i || low_w == OFS_W'($past(low_w) + 1'b1)));

    // R4: each interleaved step flips the least significant offset bit
    p_xor_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !step_n_i && order_i) |=>
            (!order_i || low_w[0] != $past(low_w[0])));

    // R5
    p_suspend_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!start_i && step_n_i) |=> (!$stable(order_i) || $stable(addr_o)));

    // R7
    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !step_n_i) |=> low_w == $past(ofs_i));

    // R8
    p_upper_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(up_w));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .step_n_i (step_n_i),
    .order_i  (order_i),
    .ofs_i    (ofs_i),
    .base_i   (base_i),
    .addr_o   (addr_o)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    localparam int ADDR_W = 15;
    localparam int OFS_W  = 2;
    localparam int UP_W   = ADDR_W - OFS_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              step_n_i = 1'b1;
    logic              order_i = 1'b0;
    logic [OFS_W-1:0]  ofs_i = '0;
    logic [UP_W-1:0]   base_i = '0;
    logic [ADDR_W-1:0] addr_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        string             tag;
    } exp_t;
    exp_t sb[$];

    // Reference state, kept from the requirements alone
    int              m_s = 0;
    int              m_k = 0;
    logic [UP_W-1:0] m_up = '0;
    bit              m_ord = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .step_n_i (step_n_i),
        .order_i  (order_i),
        .ofs_i    (ofs_i),
        .base_i   (base_i),
        .addr_o   (addr_o)
    );

    function automatic logic [ADDR_W-1:0] model_addr();
        int lo;
        lo = m_ord ? (m_s ^ (m_k % 4)) : ((m_s + m_k) % 4);
        return {m_up, OFS_W'(lo)};
    endfunction

    // Driver: apply one cycle of stimulus, then queue the expected address
    task automatic drive(input bit r, input bit st, input bit stn, input bit ord,
                         input int o, input logic [UP_W-1:0] b, input string tag);
        @(negedge clk);
        #1;
        rst = r; start_i = st; step_n_i = stn; order_i = ord;
        ofs_i = OFS_W'(o); base_i = b;
        m_ord = ord;
        if (r)        begin m_s = 0; m_k = 0; m_up = '0; end
        else if (st)  begin m_s = o; m_k = 0; m_up = b; end
        else if (!stn) m_k = (m_k + 1) % 4;
        @(posedge clk);
        #1;
        sb.push_back('{model_addr(), tag});
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (addr_o !== e.addr) begin
                errors++;
                $display("FAIL %s: addr_o=%h expected %h", e.tag, addr_o, e.addr);
            end
        end
    end

    initial begin
        // R1: reset state
        drive(1, 0, 1, 0, 0, '0, "R1");
        drive(1, 0, 1, 0, 0, '0, "R1");

        // R2 load, R3 linear steps, R6 wrap
        drive(0, 1, 1, 0, 1, 13'h1A5B, "R2");
        drive(0, 0, 0, 0, 0, '0, "R3");
        drive(0, 0, 0, 0, 0, '0, "R3");
        drive(0, 0, 0, 0, 0, '0, "R3");
        drive(0, 0, 0, 0, 0, '0, "R6");

        // R5 suspend in mid-burst
        drive(0, 0, 0, 0, 0, '0, "R3");
        drive(0, 0, 1, 0, 3, 13'h0F0F, "R5");
        drive(0, 0, 1, 0, 2, 13'h0001, "R5");
        drive(0, 0, 0, 0, 0, '0, "R3");
        drive(0, 0, 1, 0, 0, '0, "R5");

        // R8 linear wrap 3 -> 0 must not carry into upper bits
        drive(0, 1, 1, 0, 3, 13'h1FFF, "R2");
        drive(0, 0, 0, 0, 0, '0, "R8");
        drive(0, 0, 0, 0, 0, '0, "R8");

        // R7 load with a simultaneous step
        drive(0, 1, 0, 0, 2, 13'h0444, "R7");
        drive(0, 0, 0, 0, 0, '0, "R3");
        drive(0, 1, 0, 0, 0, 13'h0555, "R7");

        // R4 interleaved order; order changes only under reset
        drive(1, 0, 1, 1, 0, '0, "R1");
        drive(0, 1, 1, 1, 2, 13'h0ABC, "R2");
        drive(0, 0, 0, 1, 0, '0, "R4");
        drive(0, 0, 1, 1, 0, '0, "R5");
        drive(0, 0, 0, 1, 0, '0, "R4");
        drive(0, 0, 0, 1, 0, '0, "R4");
        drive(0, 0, 0, 1, 0, '0, "R6");
        drive(0, 1, 0, 1, 1, 13'h0777, "R7");

        // Full bursts from every offset in both orders
        for (int ord = 0; ord < 2; ord++) begin
            drive(1, 0, 1, ord[0], 0, '0, "R1");
            for (int s = 0; s < 4; s++) begin
                drive(0, 1, 1, ord[0], s, UP_W'(13'h0100 + s), "R2");
                for (int k = 1; k <= 4; k++)
                    drive(0, 0, 0, ord[0], 0, '0, (k == 4) ? "R6" : (ord == 0 ? "R3" : "R4"));
            end
        end

        drive(0, 0, 1, 1, 0, '0, "R5");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule